// File: doc/BRIEF.md
# Stream Port Get/Put Controller

This block carries out the stream transfer instructions of a small processor core against a bank of FIFO-style streaming ports. Every port has an input half (the core takes words) and an output half (the core gives words). Each word is 32 bits plus a one-bit control tag. The input half uses a data-available flag and a read strobe. The output half uses a full flag and a write strobe.

The pipeline gives the block a decoded transfer: direction, wait or no-wait, data or control tag, and probe-only. The port number comes either from an instruction field or from the low bits of a register operand. The block raises a stall for as long as a waiting transfer cannot finish. When the transfer finishes, the port strobe pulses for one cycle. On the following clock edge the block returns the read word, a carry update and a stream error update.

Top module: `stream_xfer_ctrl`

## Requirements
- R1: The port number is `op_idx` when `op_dynamic` is 0 and `rb_val[3:0]` when `op_dynamic` is 1. Only the strobe bit with that number can pulse.
- R2: A waiting get (`op_put`=0, `op_nonblock`=0) holds `stall` high and `s_read` at zero for every cycle that the selected `s_exists` is low. In the cycle the flag is high, `stall` is low and exactly the selected `s_read` bit is high.
- R3: A waiting put (`op_put`=1, `op_nonblock`=0) holds `stall` high and `m_write` at zero while the selected `m_full` is high. Once it is low, the selected `m_write` bit pulses with `m_data` = `wr_data`.
- R4: A no-wait get never stalls. It reports `carry` as the inverse of the selected `s_exists`, with `carry_we` high. When no word is present it pops nothing and returns `rd_data` = 0.
- R5: A no-wait put never stalls. It reports `carry` as the selected `m_full`, with `carry_we` high, and writes nothing when the port is full.
- R6: A put drives `m_ctrl` equal to `op_ctrl`. A get that receives a word raises `err_set` when the word's tag differs from `op_ctrl`, where 1 means control and 0 means data. No other transfer raises `err_set`.
- R7: With `op_test` set, a finishing transfer updates the carry and error results exactly as without it, but pulses no `s_read` or `m_write` bit. A probing get still returns the waiting word in `rd_data`.
- R8: `done`, `rd_data`, `carry_we`, `carry` and `err_set` are registered. They appear one cycle after the finishing cycle, `done` is a single-cycle pulse per transfer, and a waiting transfer leaves `carry_we` low.
- R9: After reset, every registered output is zero. No strobe and no stall is raised while `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A transfer is presented and held until it finishes |
| op_put | input | 1 | 1 = put to an output half, 0 = get from an input half |
| op_nonblock | input | 1 | 1 = finish at once, reporting status through carry |
| op_ctrl | input | 1 | 1 = control-tagged word, 0 = data word |
| op_test | input | 1 | Probe only: update the flags, move no word |
| op_dynamic | input | 1 | Take the port number from `rb_val` |
| op_idx | input | 4 | Port number from the instruction |
| rb_val | input | 32 | Register operand, low bits used as port number |
| wr_data | input | 32 | Word to send on a put |
| s_data | input | 512 | Input-half words, port k at bits 32k+31:32k |
| s_ctrl | input | 16 | Input-half control tags |
| s_exists | input | 16 | Input-half word-available flags |
| s_read | output | 16 | Input-half pop strobes |
| m_full | input | 16 | Output-half full flags |
| m_write | output | 16 | Output-half push strobes |
| m_data | output | 32 | Word offered to the output halves |
| m_ctrl | output | 1 | Tag offered to the output halves |
| stall | output | 1 | Pipeline hold request |
| done | output | 1 | Transfer finished in the previous cycle |
| rd_data | output | 32 | Word received by a get |
| carry_we | output | 1 | Carry flag update enable |
| carry | output | 1 | New carry flag value |
| err_set | output | 1 | Set the stream error flag |

## Verification
Gets are run with the word missing and then arriving, from both a static and a register-chosen port number. Another port holds a different word, so a wrong index would show up in `rd_data`. Puts are run against a full port and then a free one, so the stall and the withheld strobe can be told apart from a finished write. Words whose tags agree and disagree with the requested kind separate the error path from a plain completion. The same no-wait accesses are then repeated with the probe bit set, which shows that the flags still change while no strobe moves.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    typedef enum logic {
        XK_GET = 1'b0,
        XK_PUT = 1'b1
    } xfer_kind_e;

    // The selected port can take part in the transfer right now
    function automatic logic sxc_ready(input xfer_kind_e kind,
                                       input logic has_word,
                                       input logic is_full);
        return (kind == XK_PUT) ? !is_full : has_word;
    endfunction

endpackage

// File: rtl/sxc_port_mux.sv
module sxc_port_mux #(
    parameter int NPORT = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic [NPORT*DW-1:0] s_data,
    input  logic [NPORT-1:0]    s_ctrl,
    input  logic [NPORT-1:0]    s_exists,
    input  logic [NPORT-1:0]    m_full,
    input  logic [IW-1:0]       idx,
    output logic [DW-1:0]       sel_data,
    output logic                sel_ctrl,
    output logic                sel_exists,
    output logic                sel_full
);
    always_comb begin
        sel_data   = s_data[idx*DW +: DW];
        sel_ctrl   = s_ctrl[idx];
        sel_exists = s_exists[idx];
        sel_full   = m_full[idx];
    end
endmodule

// File: rtl/sxc_onehot.sv
module sxc_onehot #(
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic [N-1:0]  vec
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign vec[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/stream_xfer_ctrl.sv
module stream_xfer_ctrl #(
    parameter int NPORT = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NPORT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic                op_put,
    input  logic                op_nonblock,
    input  logic                op_ctrl,
    input  logic                op_test,
    input  logic                op_dynamic,
    input  logic [IW-1:0]       op_idx,
    input  logic [DW-1:0]       rb_val,
    input  logic [DW-1:0]       wr_data,
    input  logic [NPORT*DW-1:0] s_data,
    input  logic [NPORT-1:0]    s_ctrl,
    input  logic [NPORT-1:0]    s_exists,
    output logic [NPORT-1:0]    s_read,
    input  logic [NPORT-1:0]    m_full,
    output logic [NPORT-1:0]    m_write,
    output logic [DW-1:0]       m_data,
    output logic                m_ctrl,
    output logic                stall,
    output logic                done,
    output logic [DW-1:0]       rd_data,
    output logic                carry_we,
    output logic                carry,
    output logic                err_set
);
    import sxc_pkg::*;

    typedef struct packed {
        logic          done;
        logic [DW-1:0] rdata;
        logic          carry_we;
        logic          carry;
        logic          err_set;
    } res_t;

    res_t res_d, res_q;

    logic [IW-1:0] sel_idx;
    logic [DW-1:0] sel_data;
    logic          sel_ctrl, sel_exists, sel_full;
    logic          ready, finish, move;
    logic          pop_en, push_en;
    xfer_kind_e    kind;
    logic          unused_rb;

    assign unused_rb = ^rb_val[DW-1:IW];
    assign kind      = op_put ? XK_PUT : XK_GET;
    assign sel_idx   = op_dynamic ? rb_val[IW-1:0] : op_idx;

    sxc_port_mux #(.NPORT(NPORT), .DW(DW)) mux_i (
        .s_data    (s_data),
        .s_ctrl    (s_ctrl),
        .s_exists  (s_exists),
        .m_full    (m_full),
        .idx       (sel_idx),
        .sel_data  (sel_data),
        .sel_ctrl  (sel_ctrl),
        .sel_exists(sel_exists),
        .sel_full  (sel_full)
    );

    always_comb begin
        ready   = sxc_ready(kind, sel_exists, sel_full);
        finish  = op_valid && (op_nonblock || ready);
        move    = finish && ready && !op_test;
        pop_en  = move && (kind == XK_GET);
        push_en = move && (kind == XK_PUT);
        stall   = op_valid && !op_nonblock && !ready;

        res_d          = '0;
        res_d.done     = finish;
        res_d.carry_we = finish && op_nonblock;
        if (finish && op_nonblock) begin
            res_d.carry = (kind == XK_PUT) ? sel_full : !sel_exists;
        end
        if (finish && (kind == XK_GET) && sel_exists) begin
            res_d.rdata   = sel_data;
            res_d.err_set = (sel_ctrl != op_ctrl);
        end
    end

    sxc_onehot #(.N(NPORT)) rd_dec_i (
        .idx(sel_idx),
        .en (pop_en),
        .vec(s_read)
    );

    sxc_onehot #(.N(NPORT)) wr_dec_i (
        .idx(sel_idx),
        .en (push_en),
        .vec(m_write)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign m_data   = wr_data;
    assign m_ctrl   = op_ctrl;
    assign done     = res_q.done;
    assign rd_data  = res_q.rdata;
    assign carry_we = res_q.carry_we;
    assign carry    = res_q.carry;
    assign err_set  = res_q.err_set;

endmodule

// File: rtl/stream_xfer_ctrl_chk.sv
module stream_xfer_ctrl_chk #(
    parameter int NPORT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_nonblock,
    input logic             op_test,
    input logic             stall,
    input logic [NPORT-1:0] s_read,
    input logic [NPORT-1:0] m_write,
    input logic             done,
    input logic             carry_we,
    input logic             err_set
);
    // R2 R3: a held transfer moves no word
    assert_stall_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (s_read == '0 && m_write == '0));

    // R1: at most one strobe across both port halves
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_read, m_write}));

    // R4 R5: no-wait transfers never hold the pipeline
    assert_nowait_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_nonblock) |-> !stall);

    // R7: probing moves no word
    assert_probe_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_test) |-> (s_read == '0 && m_write == '0));

    // R8: a strobe is followed by the completion pulse
    assert_strobe_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read != '0 || m_write != '0) |=> done);

    // R8: flag updates only accompany a completion
    assert_flags_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we || err_set) |-> done);

    // R9: nothing moves or stalls without a transfer
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!stall && s_read == '0 && m_write == '0));
endmodule

bind stream_xfer_ctrl stream_xfer_ctrl_chk #(.NPORT(NPORT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_nonblock(op_nonblock),
    .op_test    (op_test),
    .stall      (stall),
    .s_read     (s_read),
    .m_write    (m_write),
    .done       (done),
    .carry_we   (carry_we),
    .err_set    (err_set)
);

// File: tb/stream_xfer_ctrl_tb.sv
module stream_xfer_ctrl_tb_top;
    localparam int NPORT = 16;
    localparam int DW    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 0, op_put = 0, op_nonblock = 0, op_ctrl = 0;
    logic              op_test = 0, op_dynamic = 0;
    logic [3:0]        op_idx = '0;
    logic [DW-1:0]     rb_val = '0, wr_data = '0;
    logic [NPORT*DW-1:0] s_data = '0;
    logic [NPORT-1:0]  s_ctrl = '0, s_exists = '0, m_full = '0;
    logic [NPORT-1:0]  s_read, m_write;
    logic [DW-1:0]     m_data, rd_data;
    logic              m_ctrl, stall, done, carry_we, carry, err_set;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    stream_xfer_ctrl #(.NPORT(NPORT), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_put(op_put),
        .op_nonblock(op_nonblock), .op_ctrl(op_ctrl), .op_test(op_test),
        .op_dynamic(op_dynamic), .op_idx(op_idx), .rb_val(rb_val),
        .wr_data(wr_data), .s_data(s_data), .s_ctrl(s_ctrl),
        .s_exists(s_exists), .s_read(s_read), .m_full(m_full),
        .m_write(m_write), .m_data(m_data), .m_ctrl(m_ctrl), .stall(stall),
        .done(done), .rd_data(rd_data), .carry_we(carry_we), .carry(carry),
        .err_set(err_set)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic set_slave(int p, logic has, logic tag, logic [31:0] w);
        s_exists[p]        = has;
        s_ctrl[p]          = tag;
        s_data[p*DW +: DW] = w;
    endtask

    // Present a transfer (call at a negative edge)
    task automatic issue(logic put, logic nb, logic tag, logic tst,
                         logic dyn, logic [3:0] idx, logic [31:0] rb,
                         logic [31:0] wd);
        op_valid = 1; op_put = put; op_nonblock = nb; op_ctrl = tag;
        op_test = tst; op_dynamic = dyn; op_idx = idx; rb_val = rb;
        wr_data = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 0; op_test = 0; op_dynamic = 0;
    endtask

    // Wait for the edge that registers the result, sample after it
    task automatic to_result();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R9 done", 32'(done), 0);
        chk("R9 rd_data", rd_data, 0);
        chk("R9 carry_we", 32'(carry_we), 0);
        chk("R9 stall", 32'(stall), 0);
        chk("R9 strobes", 32'({s_read, m_write}), 0);
    endtask

    task automatic t_get_wait();
        @(negedge clk);
        set_slave(5, 0, 0, 32'hCAFE_0005);
        issue(0, 0, 0, 0, 0, 4'd5, 0, 0);
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R2 stall while empty", 32'(stall), 1);
            chk("R2 no pop while empty", 32'(s_read), 0);
            to_result();
            chk("R8 no done while waiting", 32'(done), 0);
            @(negedge clk);
        end
        s_exists[5] = 1;
        #1;
        chk("R2 stall released", 32'(stall), 0);
        chk("R2 pop strobe", 32'(s_read), 32'h0020);
        to_result();
        chk("R8 done", 32'(done), 1);
        chk("R2 rd_data", rd_data, 32'hCAFE_0005);
        chk("R8 waiting get no carry_we", 32'(carry_we), 0);
        chk("R6 matched tag no error", 32'(err_set), 0);
        idle();
        s_exists[5] = 0;
        #1;
        to_result();
        chk("R8 done pulse ends", 32'(done), 0);
    endtask

    task automatic t_get_dynamic();
        @(negedge clk);
        set_slave(3, 1, 0, 32'h3333_3333);
        set_slave(9, 1, 0, 32'h9999_0009);
        issue(0, 0, 0, 0, 1, 4'd3, 32'hFFFF_FFF9, 0);
        #1;
        chk("R1 register index strobe", 32'(s_read), 32'h0200);
        to_result();
        chk("R1 register index data", rd_data, 32'h9999_0009);
        idle();
        set_slave(3, 0, 0, 0);
        set_slave(9, 0, 0, 0);
    endtask

    task automatic t_get_nowait();
        @(negedge clk);
        set_slave(2, 0, 0, 32'h2222_2222);
        issue(0, 1, 0, 0, 0, 4'd2, 0, 0);
        #1;
        chk("R4 empty no stall", 32'(stall), 0);
        chk("R4 empty no pop", 32'(s_read), 0);
        to_result();
        chk("R4 empty carry_we", 32'(carry_we), 1);
        chk("R4 empty carry", 32'(carry), 1);
        chk("R4 empty rd_data zero", rd_data, 0);
        chk("R6 empty no error", 32'(err_set), 0);
        @(negedge clk);
        s_exists[2] = 1;
        #1;
        chk("R4 present pop", 32'(s_read), 32'h0004);
        to_result();
        chk("R4 present carry", 32'(carry), 0);
        chk("R4 present data", rd_data, 32'h2222_2222);
        idle();
        set_slave(2, 0, 0, 0);
    endtask

    task automatic t_tag_mismatch();
        @(negedge clk);
        set_slave(7, 1, 1, 32'h7777_0001);
        issue(0, 1, 0, 0, 0, 4'd7, 0, 0);
        to_result();
        chk("R6 data get on control word", 32'(err_set), 1);
        @(negedge clk);
        op_ctrl = 1;
        to_result();
        chk("R6 control get on control word", 32'(err_set), 0);
        @(negedge clk);
        s_ctrl[7] = 0;
        to_result();
        chk("R6 control get on data word", 32'(err_set), 1);
        idle();
        set_slave(7, 0, 0, 0);
    endtask

    task automatic t_put_wait();
        @(negedge clk);
        m_full[4] = 1;
        issue(1, 0, 1, 0, 0, 4'd4, 0, 32'h0000_1234);
        for (int i = 0; i < 2; i++) begin
            #1;
            chk("R3 stall while full", 32'(stall), 1);
            chk("R3 no push while full", 32'(m_write), 0);
            @(negedge clk);
        end
        m_full[4] = 0;
        #1;
        chk("R3 push strobe", 32'(m_write), 32'h0010);
        chk("R3 m_data", m_data, 32'h0000_1234);
        chk("R6 m_ctrl follows request", 32'(m_ctrl), 1);
        to_result();
        chk("R8 put done", 32'(done), 1);
        chk("R6 put no error", 32'(err_set), 0);
        idle();
    endtask

    task automatic t_put_nowait();
        @(negedge clk);
        m_full[11] = 1;
        issue(1, 1, 0, 0, 0, 4'd11, 0, 32'hABCD_0011);
        #1;
        chk("R5 full no stall", 32'(stall), 0);
        chk("R5 full no push", 32'(m_write), 0);
        to_result();
        chk("R5 full carry", 32'(carry), 1);
        chk("R5 full carry_we", 32'(carry_we), 1);
        @(negedge clk);
        m_full[11] = 0;
        #1;
        chk("R5 free push", 32'(m_write), 32'h0800);
        chk("R6 data put tag", 32'(m_ctrl), 0);
        to_result();
        chk("R5 free carry", 32'(carry), 0);
        idle();
    endtask

    task automatic t_probe();
        @(negedge clk);
        set_slave(6, 1, 1, 32'h6666_0006);
        issue(0, 1, 0, 1, 0, 4'd6, 0, 0);
        #1;
        chk("R7 probe get no pop", 32'(s_read), 0);
        to_result();
        chk("R7 probe get carry", 32'(carry), 0);
        chk("R7 probe get carry_we", 32'(carry_we), 1);
        chk("R7 probe get peek", rd_data, 32'h6666_0006);
        chk("R7 probe get error", 32'(err_set), 1);
        @(negedge clk);
        issue(1, 1, 0, 1, 0, 4'd6, 0, 32'h1);
        #1;
        chk("R7 probe put no push", 32'(m_write), 0);
        to_result();
        chk("R7 probe put carry", 32'(carry), 0);
        idle();
        set_slave(6, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_get_wait();
        t_get_dynamic();
        t_get_nowait();
        t_tag_mismatch();
        t_put_wait();
        t_put_nowait();
        t_probe();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule